// File: doc/BRIEF.md
# Counter-Based Pulse-Width Modulator

The block produces a single pulse-width modulated output from a free-running binary step counter and a registered compare stage. With the default 4-bit width, one output period is 16 counter steps. A 4-bit duty word chooses how many of those steps drive the output high. Codes 1 to 15 give that many high steps. Code 0 gives a fully high period, so the 16 codes cover duty cycles 1/16 through 16/16.

The counter advances only on clocks where the step enable is high. A slow PWM rate is obtained by pulsing that enable once every N clocks; no derived or gated clock is used. The duty word is captured only when the counter rolls over to zero. A host may therefore change it at any moment without producing a clipped or stretched pulse. The output comes straight from a flip-flop, so it carries no compare glitches.

Top module: `pwm_gen`

## Requirements
- R1: A period is 2^CNT_W enabled steps (16 by default), starting when the counter rolls over to step 0. In every period the output is high on the steps numbered below the period's duty and low on all later steps, so step 0 is always high.
- R2: With a latched duty code d in 1..15, the output is high for exactly d of the 16 enabled steps in that period.
- R3: With a latched duty code of 0, the output is high on all 16 steps of the period.
- R4: The duty word is captured only on the enabled clock that rolls the counter from its maximum value to 0. A change made at any other time takes effect in the following period, and the current period keeps its old duty.
- R5: While the step enable is low, the counter, the latched duty and the output all hold their values.
- R6: Asynchronous active-low reset forces the output low. The first enabled clock after reset starts a period at step 0 that uses the duty word present on that clock.
- R7: The output is a registered signal that changes only on an enabled clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Step enable; the counter advances on clocks where this is high |
| w_i | input | CNT_W | Duty word; 0 selects a fully high period |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Each enabled clock edge moves the output to the value for the new step, with one register on the path. The bench therefore reads one output sample per step at the falling edge after each enabled rising edge. A duty word applied just after a rollover is due only one full period (16 enabled steps) later. The bench measures the period in which it applies a word against the old duty and the next period against the new one. Enable gaps and the asynchronous reset are checked at the falling edges inside the gap, or a short delay after reset is asserted.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int unsigned PWM_MAX_W = 16;

  // high on steps below duty; duty code 0 means the whole period
  function automatic logic duty_hit(input logic [PWM_MAX_W-1:0] step,
                                    input logic [PWM_MAX_W-1:0] duty);
    return (duty == '0) || (step < duty);
  endfunction

endpackage

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = en_i ? cnt_q + 1'b1 : cnt_q;
  assign wrap_o    = en_i && (cnt_q == CNT_MAX);
  assign cnt_o     = cnt_q;

  // parked at max so the first enabled step rolls over into step 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= CNT_MAX;
    else if (en_i) cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] w_i,
  output logic [CNT_W-1:0] duty_o,
  output logic [CNT_W-1:0] duty_nxt_o
);

  logic [CNT_W-1:0] duty_q;

  assign duty_nxt_o = load_i ? w_i : duty_q;
  assign duty_o     = duty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_q <= '0;
    else         duty_q <= duty_nxt_o;
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] duty_nxt_i,
  output logic             pwm_o
);

  logic hit;
  logic pwm_q;

  // compare against next-state values so the flop lines up with the step
  assign hit = duty_hit(PWM_MAX_W'(cnt_nxt_i), PWM_MAX_W'(duty_nxt_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pwm_q <= 1'b0;
    else if (en_i) pwm_q <= hit;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] w_i,
  output logic             pwm_o
);

  if (CNT_W < 2 || CNT_W > PWM_MAX_W) begin : g_bad_width
    initial $error("pwm_gen: CNT_W out of range");
  end

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_nxt;
  logic             wrap;

  pwm_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  pwm_duty_latch #(.CNT_W(CNT_W)) u_duty (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wrap),
    .w_i        (w_i),
    .duty_o     (duty_q),
    .duty_nxt_o (duty_nxt)
  );

  pwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .cnt_nxt_i  (cnt_nxt),
    .duty_nxt_i (duty_nxt),
    .pwm_o      (pwm_o)
  );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] w_i,
  input logic             pwm_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] duty_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic started_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   started_q <= 1'b0;
    else if (en_i) started_q <= 1'b1;
  end

  // R1
  rollover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R1
  step0_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && cnt_q == '0) |-> pwm_o);

  // R2
  tail_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && duty_q != '0 && cnt_q >= duty_q) |-> !pwm_o);

  // R3
  full_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_MAX && w_i == '0) |=> pwm_o);

  // R4
  duty_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == CNT_MAX) |=> (duty_q == $past(w_i)));

  // R4
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && cnt_q == CNT_MAX) |=> $stable(duty_q));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(pwm_o)));

  // R6
  reset_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !pwm_o);

endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W)) u_pwm_gen_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .w_i    (w_i),
  .pwm_o  (pwm_o),
  .cnt_q  (cnt_q),
  .duty_q (duty_q)
);

// File: tb/pwm_gen_bench.sv
`timescale 1ns/1ps
module pwm_gen_bench;

  localparam int unsigned CNT_W = 4;
  localparam int          STEPS = 16;

  // duty word and expected high steps per period
  localparam logic [3:0] VEC_W [16] = '{4'd3, 4'd0, 4'd15, 4'd1, 4'd8, 4'd2, 4'd14, 4'd7,
                                         4'd9, 4'd4, 4'd12, 4'd5, 4'd11, 4'd6, 4'd13, 4'd10};
  localparam int VEC_H [16] = '{3, 16, 15, 1, 8, 2, 14, 7, 9, 4, 12, 5, 11, 6, 13, 10};

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b1;
  logic [CNT_W-1:0] w_i = 4'd5;
  logic             pwm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pwm_gen #(.CNT_W(CNT_W)) u_pwm_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .w_i    (w_i),
    .pwm_o  (pwm_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at the falling edge of step 0; ends at step 0 of the next period
  task automatic measure(input int exp_high, input string req, input int gap);
    int high = 0;
    int bad = 0;
    for (int i = 0; i < STEPS; i++) begin
      logic s;
      s = pwm_o;
      if (s) high++;
      if (s != (i < exp_high)) bad++;
      if (gap > 0) begin
        en_i = 1'b0;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk_i);
          if (pwm_o != s) bad++;
        end
        en_i = 1'b1;
      end
      @(negedge clk_i);
    end
    check(high == exp_high, req, high, exp_high);
    check(bad == 0, {req, " step pattern"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(pwm_o == 1'b0, "R6 reset low", pwm_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    // R6: first period uses w present on the first enabled edge
    measure(5, "R6 first period", 0);

    for (int v = 0; v < 16; v++) begin
      int prev;
      prev = (v == 0) ? 5 : VEC_H[v-1];
      w_i = VEC_W[v];
      // R4: word changed after rollover; current period keeps old duty
      measure(prev, "R4 old duty held", 0);
      // R2 / R3: new duty over the next period
      measure(VEC_H[v], (VEC_W[v] == 4'd0) ? "R3 full duty" : "R2 duty count", 0);
    end

    // R5 / R7: enable gaps freeze counter and output
    w_i = 4'd6;
    measure(10, "R4 old duty before gaps", 0);
    measure(6, "R5 gapped period", 3);
    w_i = 4'd0;
    measure(6, "R4 old duty before gapped full", 0);
    measure(16, "R5 gapped full duty", 2);

    // R1: change mid-period does not disturb the running period
    w_i = 4'd9;
    measure(16, "R4 pre", 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_i);
      if (i == 3) w_i = 4'd2;
    end
    for (int i = 0; i < STEPS - 7; i++) @(negedge clk_i);
    measure(2, "R1 mid-period change", 0);

    // R6: asynchronous reset mid-period
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check(pwm_o == 1'b0, "R6 async reset", pwm_o, 0);
    w_i = 4'd0;
    repeat (2) @(negedge clk_i);
    check(pwm_o == 1'b0, "R6 held in reset", pwm_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    measure(16, "R6 restart full", 0);
    w_i = 4'd1;
    measure(16, "R4 restart old", 0);
    measure(1, "R2 minimum duty", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule